// File: doc/BRIEF.md
# Branch Tail-Pointer Checkpoint Table

This block keeps a recovery point for every branch that is in flight in an out-of-order core. The rename table holds one queue of physical registers for each architectural register. When a branch passes rename, the tail pointers of all of those queues are copied as one wide word into a free slot of this table. The slot number is handed back as the branch's identifier. Slots are used in a ring, in program order. When the oldest branch resolves correctly, its slot is released.

On a misprediction the core presents the faulting branch's identifier. The table reads that slot and, after a configurable latency of one or two cycles, delivers the saved tail pointers so that the rename table can overwrite all of its tail registers at once. The write position of the ring moves back to the faulting slot, which drops that checkpoint and every younger one. A busy flag covers the restore window. While it is high, no new operation is accepted.

Top module: `brck_table`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `empty`=1, `full`=0, `busy`=0, `restore_valid`=0 and `alloc_id`=0.
- R2: `alloc_id` always shows the identifier that the next branch will receive, which is the next free slot index. An accepted allocation stores `alloc_tails` in that slot and increments `alloc_id` modulo DEPTH.
- R3: `full` is high exactly when DEPTH checkpoints are live. An allocation request while full is ignored: `alloc_id`, `full` and the stored data do not change.
- R4: An accepted `retire_req` frees the oldest live checkpoint. `empty` is high exactly when no checkpoint is live, and a retire request while empty is ignored.
- R5: When a squash of a live identifier is accepted, `restore_tails` carries the word stored for that identifier. Field i (bits i*PTR_W upward) is the tail of architectural register i.
- R6: An accepted squash of identifier S keeps only the checkpoints older than S. Afterwards `alloc_id` equals S and the live count equals the distance from the oldest live slot to S.
- R7: After an accepted squash, `busy` is high for exactly RESTORE_CYCLES cycles, starting in the next cycle. `restore_valid` is high only in the last of those cycles. Alloc, retire and squash requests made while `busy` is high are ignored.
- R8: A squash whose identifier is not live, including any squash on an empty table, is ignored: `busy` stays low and the pointers do not move.
- R9: In a cycle where `squash_req` is high, any alloc or retire request is ignored, whether or not the squash is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | A branch is at rename and needs a checkpoint |
| alloc_tails | input | NUM_ARCH*PTR_W | Current tail pointer of every architectural register |
| alloc_id | output | ID_W | Identifier for the next branch (the next free slot) |
| full | output | 1 | All slots are live, so further branch renames must stall |
| empty | output | 1 | No slot is live |
| retire_req | input | 1 | The oldest branch resolved correctly |
| squash_req | input | 1 | A misprediction was detected |
| squash_id | input | ID_W | Identifier of the faulting branch |
| busy | output | 1 | A restore is in progress |
| restore_valid | output | 1 | `restore_tails` is to be written into the rename table this cycle |
| restore_tails | output | NUM_ARCH*PTR_W | Saved tail pointers of the faulting branch |

## Verification
The bench runs a four-slot, four-register configuration with a two-cycle restore. It squashes every offset at every fill level, starting from ring positions that have wrapped. A design that computed the new write position without the offset from the oldest slot would report the wrong `alloc_id`. It would also leave `empty` asserting after the wrong number of retires. The bench squashes identifiers one and two past the live region and on an empty table; a design that did not check liveness would raise `busy` and corrupt the ring. It raises alloc and retire together with a squash, and again during the restore window. A design that let them through would advance `alloc_id`, or would deliver a word that the colliding allocation had overwritten.

// File: rtl/brck_pkg.sv
package brck_pkg;

   // operations accepted in one cycle
   typedef struct packed {
      logic alloc;
      logic retire;
      logic squash;
   } brck_ops_t;

   localparam int unsigned BRCK_MAX_RESTORE = 2;

endpackage

// File: rtl/brck_arb.sv
module brck_arb
   import brck_pkg::*;
#(
   parameter int unsigned ID_W = 3
) (
   input  logic            alloc_req,
   input  logic            retire_req,
   input  logic            squash_req,
   input  logic [ID_W-1:0] squash_id,
   input  logic            busy,
   input  logic [ID_W-1:0] rd_idx,
   input  logic [ID_W:0]   occ,
   input  logic            full,
   input  logic            empty,
   output brck_ops_t       ops,
   output logic [ID_W-1:0] sq_off
);

   logic sq_live;

   always_comb begin
      sq_off     = squash_id - rd_idx;
      sq_live    = ({1'b0, sq_off} < occ);
      ops.squash = squash_req && !busy && sq_live;
      ops.alloc  = alloc_req  && !busy && !full  && !squash_req;
      ops.retire = retire_req && !busy && !empty && !squash_req;
   end

endmodule

// File: rtl/brck_ptr_ctrl.sv
module brck_ptr_ctrl
   import brck_pkg::*;
#(
   parameter int unsigned ID_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  brck_ops_t       ops,
   input  logic [ID_W-1:0] sq_off,
   output logic [ID_W-1:0] wr_idx,
   output logic [ID_W-1:0] rd_idx,
   output logic [ID_W:0]   occ
);

   logic [ID_W:0] wr_q, rd_q, wr_d, rd_d;

   always_comb begin
      wr_d = wr_q;
      rd_d = rd_q;
      if (ops.squash) begin
         wr_d = rd_q + {1'b0, sq_off};
      end else if (ops.alloc) begin
         wr_d = wr_q + 1'b1;
      end
      if (ops.retire) begin
         rd_d = rd_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         wr_q <= wr_d;
         rd_q <= rd_d;
      end
   end

   assign wr_idx = wr_q[ID_W-1:0];
   assign rd_idx = rd_q[ID_W-1:0];
   assign occ    = wr_q - rd_q;

endmodule

// File: rtl/brck_store.sv
module brck_store #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned ID_W    = 3,
   parameter int unsigned ENTRY_W = 64
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [ID_W-1:0]    wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [ID_W-1:0]    rd_idx,
   output logic [ENTRY_W-1:0] rd_data
);

   logic [ENTRY_W-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == ID_W'(s))) begin
            slot_q[s] <= wr_data;
         end
      end
   end

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/brck_restore_pipe.sv
module brck_restore_pipe #(
   parameter int unsigned ENTRY_W        = 64,
   parameter int unsigned RESTORE_CYCLES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ENTRY_W-1:0] start_data,
   output logic               busy,
   output logic               out_valid,
   output logic [ENTRY_W-1:0] out_data
);

   logic               v1_q;
   logic [ENTRY_W-1:0] d1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         d1_q <= '0;
      end else begin
         v1_q <= start;
         if (start) d1_q <= start_data;
      end
   end

   if (RESTORE_CYCLES == 1) begin : g_one
      assign busy      = v1_q;
      assign out_valid = v1_q;
      assign out_data  = d1_q;
   end else begin : g_two
      logic               v2_q;
      logic [ENTRY_W-1:0] d2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v2_q <= 1'b0;
            d2_q <= '0;
         end else begin
            v2_q <= v1_q;
            if (v1_q) d2_q <= d1_q;
         end
      end
      assign busy      = v1_q | v2_q;
      assign out_valid = v2_q;
      assign out_data  = d2_q;
   end

endmodule

// File: rtl/brck_table.sv
module brck_table
   import brck_pkg::*;
#(
   parameter int unsigned NUM_ARCH       = 8,
   parameter int unsigned NUM_PHYS       = 256,
   parameter int unsigned DEPTH          = 8,
   parameter int unsigned RESTORE_CYCLES = 1,
   localparam int unsigned PTR_W   = $clog2(NUM_PHYS),
   localparam int unsigned ID_W    = $clog2(DEPTH),
   localparam int unsigned ENTRY_W = NUM_ARCH * PTR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_req,
   input  logic [ENTRY_W-1:0] alloc_tails,
   output logic [ID_W-1:0]    alloc_id,
   output logic               full,
   output logic               empty,
   input  logic               retire_req,
   input  logic               squash_req,
   input  logic [ID_W-1:0]    squash_id,
   output logic               busy,
   output logic               restore_valid,
   output logic [ENTRY_W-1:0] restore_tails
);

   if (DEPTH < 2 || (1 << ID_W) != DEPTH) begin : g_bad_depth
      $error("brck_table: DEPTH must be a power of two, at least 2");
   end
   if (RESTORE_CYCLES < 1 || RESTORE_CYCLES > BRCK_MAX_RESTORE) begin : g_bad_lat
      $error("brck_table: RESTORE_CYCLES must be 1 or 2");
   end
   if (NUM_ARCH < 1 || NUM_PHYS < 2) begin : g_bad_regs
      $error("brck_table: register counts out of range");
   end

   brck_ops_t          ops;
   logic [ID_W-1:0]    sq_off, wr_idx, rd_idx;
   logic [ID_W:0]      occ;
   logic [ENTRY_W-1:0] rd_data;

   assign full     = (occ == (ID_W+1)'(DEPTH));
   assign empty    = (occ == '0);
   assign alloc_id = wr_idx;

   brck_arb #(.ID_W(ID_W)) u_arb (
      .alloc_req (alloc_req),
      .retire_req(retire_req),
      .squash_req(squash_req),
      .squash_id (squash_id),
      .busy      (busy),
      .rd_idx    (rd_idx),
      .occ       (occ),
      .full      (full),
      .empty     (empty),
      .ops       (ops),
      .sq_off    (sq_off)
   );

   brck_ptr_ctrl #(.ID_W(ID_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ops   (ops),
      .sq_off(sq_off),
      .wr_idx(wr_idx),
      .rd_idx(rd_idx),
      .occ   (occ)
   );

   brck_store #(.DEPTH(DEPTH), .ID_W(ID_W), .ENTRY_W(ENTRY_W)) u_store (
      .clk    (clk),
      .wr_en  (ops.alloc),
      .wr_idx (wr_idx),
      .wr_data(alloc_tails),
      .rd_idx (squash_id),
      .rd_data(rd_data)
   );

   brck_restore_pipe #(.ENTRY_W(ENTRY_W), .RESTORE_CYCLES(RESTORE_CYCLES)) u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ops.squash),
      .start_data(rd_data),
      .busy      (busy),
      .out_valid (restore_valid),
      .out_data  (restore_tails)
   );

endmodule

// File: rtl/brck_table_chk.sv
module brck_table_chk #(
   parameter int unsigned ID_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            alloc_req,
   input logic [ID_W-1:0] alloc_id,
   input logic            full,
   input logic            empty,
   input logic            squash_req,
   input logic            busy,
   input logic            restore_valid
);

   // R1
   never_full_and_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R2
   alloc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !full && !busy && !squash_req) |=> (alloc_id == $past(alloc_id) + 1'b1));

   // R3
   alloc_full_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !squash_req && !busy) |=> (alloc_id == $past(alloc_id)));

   // R7
   valid_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> busy);

   // R7
   busy_freezes_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(alloc_id));

   // R8
   empty_squash_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_req && empty && !busy) |=> !busy);

endmodule

bind brck_table brck_table_chk #(.ID_W(ID_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_req    (alloc_req),
   .alloc_id     (alloc_id),
   .full         (full),
   .empty        (empty),
   .squash_req   (squash_req),
   .busy         (busy),
   .restore_valid(restore_valid)
);

// File: tb/brck_table_tb.sv
module brck_table_tb;

   localparam int D  = 4;
   localparam int NA = 4;
   localparam int NP = 16;
   localparam int RC = 2;
   localparam int PW = 4;
   localparam int IW = 2;
   localparam int EW = NA * PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0;
   logic [EW-1:0] alloc_tails = '0;
   logic [IW-1:0] alloc_id;
   logic          full, empty;
   logic          retire_req = 1'b0;
   logic          squash_req = 1'b0;
   logic [IW-1:0] squash_id = '0;
   logic          busy, restore_valid;
   logic [EW-1:0] restore_tails;

   brck_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .DEPTH(D), .RESTORE_CYCLES(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_tails(alloc_tails),
      .alloc_id(alloc_id), .full(full), .empty(empty), .retire_req(retire_req),
      .squash_req(squash_req), .squash_id(squash_id), .busy(busy),
      .restore_valid(restore_valid), .restore_tails(restore_tails)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int head = 0;
   int occ = 0;
   int seed = 1;
   bit done = 0;
   logic [EW-1:0] snap [D];

   function automatic logic [EW-1:0] mk(int s);
      logic [EW-1:0] v;
      for (int r = 0; r < NA; r++) v[r*PW +: PW] = PW'(s * 3 + r * 5 + 1);
      return v;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_state(string req);
      chk({req, " full"}, int'(full), int'(occ == D));
      chk({req, " empty"}, int'(empty), int'(occ == 0));
      chk({req, " alloc_id"}, int'(alloc_id), (head + occ) % D);
   endtask

   task automatic alloc_one();
      chk("R2 id before alloc", int'(alloc_id), (head + occ) % D);
      alloc_req = 1'b1;
      alloc_tails = mk(seed);
      step();
      alloc_req = 1'b0;
      if (occ < D) begin
         snap[(head + occ) % D] = mk(seed);
         occ++;
      end
      seed++;
   endtask

   task automatic retire_one();
      retire_req = 1'b1;
      step();
      retire_req = 1'b0;
      if (occ > 0) begin
         head = (head + 1) % D;
         occ--;
      end
   endtask

   task automatic drain();
      while (occ > 0) begin
         retire_one();
         chk_state("R4 drain");
      end
   endtask

   task automatic squash(int id, bit with_alloc, bit with_retire);
      int off;
      bit live;
      off = (id - head + D) % D;
      live = off < occ;
      squash_req = 1'b1;
      squash_id = IW'(id);
      alloc_req = with_alloc;
      alloc_tails = ~mk(seed);
      retire_req = with_retire;
      step();
      squash_req = 1'b0;
      alloc_req = 1'b0;
      retire_req = 1'b0;
      if (live) begin
         chk("R7 busy first", int'(busy), 1);
         chk("R7 valid early", int'(restore_valid), 0);
         // requests during the restore window must be ignored (R7)
         alloc_req = 1'b1;
         retire_req = 1'b1;
         squash_req = 1'b1;
         squash_id = IW'(head);
         step();
         alloc_req = 1'b0;
         retire_req = 1'b0;
         squash_req = 1'b0;
         chk("R7 busy second", int'(busy), 1);
         chk("R7 valid last", int'(restore_valid), 1);
         chk("R5 restore word", int'(restore_tails), int'(snap[id]));
         step();
         chk("R7 busy ends", int'(busy), 0);
         occ = off;
         chk_state("R6 after squash");
      end else begin
         chk("R8 no busy", int'(busy), 0);
         chk_state("R8 ring unchanged");
      end
   endtask

   initial begin
      repeat (3) step();
      chk("R1 busy", int'(busy), 0);
      chk("R1 valid", int'(restore_valid), 0);
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 alloc_id", int'(alloc_id), 0);
      rst_n = 1'b1;
      step();
      chk_state("R1 after release");

      // fill, overfill, drain, overdrain
      repeat (D) alloc_one();
      chk_state("R3 full");
      alloc_one();
      chk_state("R3 alloc ignored");
      drain();
      retire_one();
      chk_state("R4 retire on empty");

      // move the ring around so that ids wrap
      for (int r = 0; r < 3; r++) begin
         repeat (r + 2) alloc_one();
         retire_one();
         chk_state("R2 wrap");
      end
      drain();

      // sweep every fill level and every squash offset
      for (int n = 1; n <= D; n++) begin
         for (int k = 0; k < n; k++) begin
            drain();
            retire_one();
            repeat (n) alloc_one();
            squash((head + k) % D, 1'b0, 1'b0);
            alloc_one();
            chk_state("R6 realloc");
         end
      end

      // ids outside the live region
      drain();
      repeat (2) alloc_one();
      squash((head + 2) % D, 1'b0, 1'b0);
      squash((head + 3) % D, 1'b1, 1'b1);
      chk_state("R9 blocked by invalid squash");
      drain();
      squash(head, 1'b0, 1'b0);

      // collision of squash with alloc and retire
      repeat (3) alloc_one();
      squash((head + 1) % D, 1'b1, 1'b1);
      chk_state("R9 squash wins");
      drain();

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule